// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns words taken from an external transmit queue into asynchronous serial frames on a single line. Each frame has a low start bit, a data field, an optional parity bit and a stop period. The data field is 5 to 9 bits wide and can be sent least or most significant bit first. The stop period can be set in half-bit steps. All timing comes from a per-bit oversample count of system clock cycles. The queue is read through an empty flag, a read-data bus and a single-cycle pop strobe. Storage for the queue sits outside this block.

An optional clear-to-send input, with programmable polarity, holds back each new frame until the far end is ready. A frame that has already started always runs to its end. A multiprocessor mode sends eight data bits followed by a ninth marker bit, which tags a word as an address. The configuration inputs are static: they change only while the transmitter is idle.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txd` is 1, `tx_busy` is 0 and `fifo_pop` is 0 unless a frame is being launched.
- R2: Each frame opens with a start bit at 0 that lasts exactly `cfg_oversample` clock cycles. Every data and parity bit also lasts `cfg_oversample` cycles, with `cfg_oversample` of at least 4.
- R3: With multiprocessor mode off, the data field carries `cfg_data_bits` bits of `fifo_rdata`, where the field value is the plain binary bit count. Values below 5 act as 5, and values above 9 act as 9.
- R4: With `cfg_msb_first` = 0 the field starts with word bit 0. With `cfg_msb_first` = 1 it starts with the highest bit of the field.
- R5: `cfg_parity` codes are 2'b00 none, 2'b01 even, 2'b10 odd and 2'b11 none. The parity bit follows the data field. It makes the count of ones over the data field plus the parity bit even (even code) or odd (odd code).
- R6: The stop period holds `txd` at 1 for (h/2)·OS + (h mod 2)·⌊OS/2⌋ cycles, where h = `cfg_stop_halves` (1..7) and OS = `cfg_oversample`. A value of 0 acts as 2.
- R7: `tx_busy` is 1 from the first start-bit cycle through the last stop cycle. If a word is waiting and sending is allowed in the last stop cycle, the next start bit follows with no idle cycle in between.
- R8: With `cfg_cts_en` = 1, no word is popped and no frame starts while `cts_in` is inactive. `cfg_cts_low` = 0 makes the active level 1, and `cfg_cts_low` = 1 makes it 0.
- R9: `cts_in` is only consulted at frame boundaries, so dropping it during a frame does not shorten or alter that frame.
- R10: With `cfg_mp_en` = 1, the field is `fifo_rdata[7:0]` in the order chosen by `cfg_msb_first`, followed by `fifo_rdata[8]` as a marker bit. No parity bit is sent, and `cfg_data_bits` and `cfg_parity` are ignored.
- R11: `fifo_pop` is high for one cycle, only while `fifo_empty` is 0. The start bit appears on `txd` in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_oversample | input | OS_W | Clock cycles per bit (at least 4) |
| cfg_data_bits | input | $clog2(DATA_MAX+1) | Data field width in bits |
| cfg_msb_first | input | 1 | 1 sends the field most significant bit first |
| cfg_parity | input | 2 | Parity code (none, even, odd, none) |
| cfg_stop_halves | input | STOP_W | Stop period in half-bit steps |
| cfg_cts_en | input | 1 | Enables clear-to-send gating |
| cfg_cts_low | input | 1 | 1 makes clear-to-send active low |
| cfg_mp_en | input | 1 | Enables the multiprocessor marker-bit frame |
| cts_in | input | 1 | Clear-to-send from the receiving side, already synchronous |
| fifo_empty | input | 1 | Queue has no word |
| fifo_rdata | input | DATA_MAX | Word at the head of the queue |
| fifo_pop | output | 1 | Takes the head word this cycle |
| txd | output | 1 | Serial line, idle high |
| tx_busy | output | 1 | A frame is on the line |

## Verification
The assertions assume `cts_in` and `fifo_empty` are synchronous to `clk`. They also assume the configuration inputs do not move while `tx_busy` is high, and that `cfg_oversample` is at least 4. The bench keeps inside these limits by changing configuration only after it has seen the line go idle. It drives `cts_in` and the queue model only one nanosecond after a rising edge, and it sweeps only oversample values of 4 and 5. Clear-to-send is dropped only after a frame has visibly started, which matches the boundary-only sampling the gating assertion relies on.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } tx_state_e;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_EVEN = 2'b01,
      PAR_ODD  = 2'b10,
      PAR_OFF  = 2'b11
   } parity_e;

endpackage

// File: rtl/uart_tx_timer.sv
// Bit-period counter: counts cycles up to a programmable limit and pulses tick
// on the last cycle of each period. Held at zero while hold is high.
module uart_tx_timer #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [CNT_W-1:0] limit,
   output logic             tick
);

   logic [CNT_W-1:0] cnt;

   assign tick = !hold && (cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (hold || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/uart_tx_framer.sv
// Builds the data field in transmit order (element 0 goes out first) and the
// parity bit from the head-of-queue word and the static configuration.
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int DATA_MAX = 9,
   parameter int BITS_W   = 4,
   parameter int MIN_BITS = 5
) (
   input  logic [DATA_MAX-1:0] word,
   input  logic [BITS_W-1:0]   cfg_bits,
   input  logic                msb_first,
   input  parity_e             parity,
   input  logic                mp_en,
   output logic [DATA_MAX-1:0] field,
   output logic [BITS_W-1:0]   field_len,
   output logic                par_en,
   output logic                par_bit
);

   logic [BITS_W-1:0]   eff_len;
   logic [BITS_W-1:0]   body_len;
   logic [DATA_MAX-1:0] ordered;
   logic [DATA_MAX-1:0] keep;
   logic                raw_par;

   always_comb begin
      eff_len = cfg_bits;
      if (cfg_bits < BITS_W'(MIN_BITS)) eff_len = BITS_W'(MIN_BITS);
      if (cfg_bits > BITS_W'(DATA_MAX)) eff_len = BITS_W'(DATA_MAX);
      if (mp_en) begin
         body_len  = BITS_W'(DATA_MAX - 1);
         field_len = BITS_W'(DATA_MAX);
      end else begin
         body_len  = eff_len;
         field_len = eff_len;
      end
   end

   for (genvar g = 0; g < DATA_MAX; g++) begin : g_bit
      logic [BITS_W-1:0] idx;
      logic              in_body;
      assign idx        = body_len - BITS_W'(g + 1);
      assign in_body    = BITS_W'(g) < body_len;
      assign ordered[g] = in_body ? (msb_first ? word[idx] : word[g]) : 1'b0;
      assign keep[g]    = BITS_W'(g) < eff_len;
   end

   always_comb begin
      field = ordered;
      if (mp_en) field[DATA_MAX-1] = word[DATA_MAX-1];
   end

   assign raw_par = ^(word & keep);
   assign par_en  = !mp_en && (parity == PAR_EVEN || parity == PAR_ODD);
   assign par_bit = (parity == PAR_ODD) ? ~raw_par : raw_par;

endmodule

// File: rtl/uart_tx_seq.sv
// Frame sequencer: start, data, optional parity, stop. Loads a new frame on
// launch, which the top only raises when idle or on the last stop cycle.
module uart_tx_seq
   import uart_tx_pkg::*;
#(
   parameter int DATA_MAX = 9,
   parameter int BITS_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                launch,
   input  logic                tick,
   input  logic [DATA_MAX-1:0] field,
   input  logic [BITS_W-1:0]   field_len,
   input  logic                par_en,
   input  logic                par_bit,
   output tx_state_e           state,
   output logic                txd,
   output logic                busy
);

   logic [DATA_MAX-1:0] shreg;
   logic [BITS_W-1:0]   left;
   logic                pe_q;
   logic                pb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         shreg <= '0;
         left  <= '0;
         pe_q  <= 1'b0;
         pb_q  <= 1'b0;
      end else if (launch) begin
         state <= ST_START;
         shreg <= field;
         left  <= field_len;
         pe_q  <= par_en;
         pb_q  <= par_bit;
      end else begin
         case (state)
            ST_IDLE:  state <= ST_IDLE;
            ST_START: if (tick) state <= ST_DATA;
            ST_DATA: begin
               if (tick) begin
                  shreg <= shreg >> 1;
                  left  <= left - 1'b1;
                  if (left == BITS_W'(1)) state <= pe_q ? ST_PAR : ST_STOP;
               end
            end
            ST_PAR:   if (tick) state <= ST_STOP;
            ST_STOP:  if (tick) state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_START: txd = 1'b0;
         ST_DATA:  txd = shreg[0];
         ST_PAR:   txd = pb_q;
         default:  txd = 1'b1;
      endcase
   end

   assign busy = (state != ST_IDLE);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uart_tx_pkg::*;
#(
   parameter int DATA_MAX = 9,
   parameter int OS_W     = 8,
   parameter int STOP_W   = 3,
   parameter int MIN_BITS = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [OS_W-1:0]               cfg_oversample,
   input  logic [$clog2(DATA_MAX+1)-1:0] cfg_data_bits,
   input  logic                          cfg_msb_first,
   input  logic [1:0]                    cfg_parity,
   input  logic [STOP_W-1:0]             cfg_stop_halves,
   input  logic                          cfg_cts_en,
   input  logic                          cfg_cts_low,
   input  logic                          cfg_mp_en,
   input  logic                          cts_in,
   input  logic                          fifo_empty,
   input  logic [DATA_MAX-1:0]           fifo_rdata,
   output logic                          fifo_pop,
   output logic                          txd,
   output logic                          tx_busy
);

   localparam int BITS_W = $clog2(DATA_MAX + 1);
   localparam int CNT_W  = OS_W + STOP_W;

   initial begin
      assert (DATA_MAX >= 6 && DATA_MAX <= 16)
         else $error("uart_frame_tx: DATA_MAX out of range");
      assert (MIN_BITS >= 1 && MIN_BITS < DATA_MAX)
         else $error("uart_frame_tx: MIN_BITS out of range");
      assert (OS_W >= 3)
         else $error("uart_frame_tx: OS_W too small");
      assert (STOP_W >= 2)
         else $error("uart_frame_tx: STOP_W too small");
   end

   tx_state_e           state;
   logic                tick;
   logic                cts_ok;
   logic                at_boundary;
   logic                launch;
   logic [STOP_W-1:0]   h_eff;
   logic [CNT_W-1:0]    stop_cyc;
   logic [CNT_W-1:0]    limit;
   logic [DATA_MAX-1:0] field;
   logic [BITS_W-1:0]   field_len;
   logic                par_en;
   logic                par_bit;

   // stop period in half-bit steps
   assign h_eff    = (cfg_stop_halves == '0) ? STOP_W'(2) : cfg_stop_halves;
   assign stop_cyc = CNT_W'(h_eff >> 1) * CNT_W'(cfg_oversample)
                   + (h_eff[0] ? CNT_W'(cfg_oversample >> 1) : '0);
   assign limit    = (state == ST_STOP) ? stop_cyc : CNT_W'(cfg_oversample);

   // clear-to-send gate, consulted only at frame boundaries
   assign cts_ok      = !cfg_cts_en || (cts_in ^ cfg_cts_low);
   assign at_boundary = (state == ST_IDLE) || (state == ST_STOP && tick);
   assign launch      = at_boundary && !fifo_empty && cts_ok;
   assign fifo_pop    = launch;

   uart_tx_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (state == ST_IDLE),
      .limit (limit),
      .tick  (tick)
   );

   uart_tx_framer #(
      .DATA_MAX (DATA_MAX),
      .BITS_W   (BITS_W),
      .MIN_BITS (MIN_BITS)
   ) u_framer (
      .word      (fifo_rdata),
      .cfg_bits  (cfg_data_bits),
      .msb_first (cfg_msb_first),
      .parity    (parity_e'(cfg_parity)),
      .mp_en     (cfg_mp_en),
      .field     (field),
      .field_len (field_len),
      .par_en    (par_en),
      .par_bit   (par_bit)
   );

   uart_tx_seq #(
      .DATA_MAX (DATA_MAX),
      .BITS_W   (BITS_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .tick      (tick),
      .field     (field),
      .field_len (field_len),
      .par_en    (par_en),
      .par_bit   (par_bit),
      .state     (state),
      .txd       (txd),
      .busy      (tx_busy)
   );

endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
   parameter int OS_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [OS_W-1:0] cfg_oversample,
   input logic            cfg_cts_en,
   input logic            cfg_cts_low,
   input logic            cts_in,
   input logic            fifo_empty,
   input logic            fifo_pop,
   input logic            txd,
   input logic            tx_busy
);

   // cycles since the last pop, saturating
   logic [OS_W:0] since_pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_pop <= '1;
      end else if (fifo_pop) begin
         since_pop <= '0;
      end else if (since_pop != '1) begin
         since_pop <= since_pop + 1'b1;
      end
   end

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);

   assert_pop_starts_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> (tx_busy && !txd));

   assert_cts_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && cfg_cts_en) |-> (cts_in != cfg_cts_low));

   assert_start_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && (since_pop < {1'b0, cfg_oversample})) |-> !txd);

   assert_busy_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(fifo_pop));

endmodule

bind uart_frame_tx uart_tx_checker #(.OS_W(OS_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_oversample (cfg_oversample),
   .cfg_cts_en     (cfg_cts_en),
   .cfg_cts_low    (cfg_cts_low),
   .cts_in         (cts_in),
   .fifo_empty     (fifo_empty),
   .fifo_pop       (fifo_pop),
   .txd            (txd),
   .tx_busy        (tx_busy)
);

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg_oversample = 8'd4;
   logic [3:0] cfg_data_bits = 4'd8;
   logic       cfg_msb_first = 1'b0;
   logic [1:0] cfg_parity = 2'b00;
   logic [2:0] cfg_stop_halves = 3'd2;
   logic       cfg_cts_en = 1'b0;
   logic       cfg_cts_low = 1'b0;
   logic       cfg_mp_en = 1'b0;
   logic       cts_in = 1'b0;
   logic       fifo_empty;
   logic [8:0] fifo_rdata;
   logic       fifo_pop;
   logic       txd;
   logic       tx_busy;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   bit drop_cts = 1'b0;

   // queue model
   logic [8:0] q [0:15];
   int wr = 0;
   int rd = 0;
   assign fifo_empty = (wr == rd);
   assign fifo_rdata = q[rd[3:0]];
   always @(posedge clk) if (fifo_pop) rd <= rd + 1;

   always #2.5 clk = ~clk;

   uart_frame_tx u0 (
      .clk(clk), .rst_n(rst_n), .cfg_oversample(cfg_oversample),
      .cfg_data_bits(cfg_data_bits), .cfg_msb_first(cfg_msb_first),
      .cfg_parity(cfg_parity), .cfg_stop_halves(cfg_stop_halves),
      .cfg_cts_en(cfg_cts_en), .cfg_cts_low(cfg_cts_low), .cfg_mp_en(cfg_mp_en),
      .cts_in(cts_in), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
      .fifo_pop(fifo_pop), .txd(txd), .tx_busy(tx_busy)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic push(input logic [8:0] w);
      q[wr[3:0]] = w;
      wr = wr + 1;
   endtask

   task automatic wait_pop();
      int n = 0;
      #0.5;
      while (fifo_pop !== 1'b1 && n < 1000) begin
         step();
         n++;
      end
      check(fifo_pop === 1'b1, "R11", "pop seen", int'(fifo_pop), 1);
   endtask

   // Expects the frame for w to begin in the cycle after the pop just seen.
   task automatic check_frame(input logic [8:0] w, input bit expect_idle);
      logic  sv [0:12];
      int    sl [0:12];
      string st [0:12];
      int    ns = 0;
      int    os = int'(cfg_oversample);
      int    h  = (cfg_stop_halves == 0) ? 2 : int'(cfg_stop_halves);
      int    nb = int'(cfg_data_bits);
      logic  p  = 1'b0;
      sv[ns] = 1'b0; sl[ns] = os; st[ns] = "R2 start"; ns++;
      if (cfg_mp_en) begin
         for (int i = 0; i < 8; i++) begin
            sv[ns] = cfg_msb_first ? w[7-i] : w[i];
            sl[ns] = os; st[ns] = "R10 data"; ns++;
         end
         sv[ns] = w[8]; sl[ns] = os; st[ns] = "R10 marker"; ns++;
      end else begin
         if (nb < 5) nb = 5;
         if (nb > 9) nb = 9;
         for (int i = 0; i < nb; i++) begin
            sv[ns] = cfg_msb_first ? w[nb-1-i] : w[i];
            p = p ^ w[i];
            sl[ns] = os; st[ns] = cfg_msb_first ? "R4 data" : "R3 data"; ns++;
         end
         if (cfg_parity == 2'b01 || cfg_parity == 2'b10) begin
            sv[ns] = (cfg_parity == 2'b10) ? ~p : p;
            sl[ns] = os; st[ns] = "R5 parity"; ns++;
         end
      end
      sv[ns] = 1'b1; sl[ns] = (h / 2) * os + (h % 2) * (os / 2);
      st[ns] = "R6 stop"; ns++;
      for (int s = 0; s < ns; s++) begin
         bit bad = 1'b0;
         int got = 0;
         for (int c = 0; c < sl[s]; c++) begin
            step();
            if (txd !== sv[s] || tx_busy !== 1'b1) begin
               bad = 1'b1;
               got = int'(txd) * 10 + int'(tx_busy);
            end
            if (drop_cts && s == 0 && c == 0) cts_in = cfg_cts_low;
            if (!expect_idle && s == ns - 1 && c == sl[s] - 1)
               check(fifo_pop === 1'b1, "R7", "relaunch pop at stop end",
                     int'(fifo_pop), 1);
         end
         check(!bad, st[s], "txd*10+busy", got, int'(sv[s]) * 10 + 1);
      end
      if (expect_idle) begin
         step();
         check(txd === 1'b1 && tx_busy === 1'b0, "R7", "idle after stop txd*10+busy",
               int'(txd) * 10 + int'(tx_busy), 10);
      end
   endtask

   task automatic expect_quiet(input int n, input string tag);
      bit bad = 1'b0;
      for (int i = 0; i < n; i++) begin
         step();
         if (txd !== 1'b1 || tx_busy !== 1'b0 || fifo_pop !== 1'b0) bad = 1'b1;
      end
      check(!bad, tag, "line held idle", int'(bad), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: got running expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int k = 0;
      repeat (3) step();
      // R1: reset state
      check(txd === 1'b1 && tx_busy === 1'b0 && fifo_pop === 1'b0, "R1",
            "reset txd*100+busy*10+pop", int'(txd)*100 + int'(tx_busy)*10 + int'(fifo_pop), 100);
      rst_n = 1'b1;
      step();
      check(txd === 1'b1 && tx_busy === 1'b0, "R1", "idle after reset",
            int'(txd)*10 + int'(tx_busy), 10);

      // sweep: R2 R3 R4 R5 R6 R7 R11
      for (int os = 4; os <= 5; os++)
         for (int nb = 5; nb <= 9; nb++)
            for (int m = 0; m < 2; m++)
               for (int pr = 0; pr < 4; pr++)
                  for (int h = 1; h <= 4; h++) begin
                     cfg_oversample  = 8'(os);
                     cfg_data_bits   = 4'(nb);
                     cfg_msb_first   = m[0];
                     cfg_parity      = 2'(pr);
                     cfg_stop_halves = 3'(h);
                     k++;
                     push(9'((k * 37 + 11) ^ (k << 4)));
                     wait_pop();
                     check_frame(q[(wr - 1) & 15], 1'b1);
                  end

      // R6 corner codes: 0 acts as 2, 7 with even oversample
      cfg_oversample = 8'd6; cfg_data_bits = 4'd5; cfg_parity = 2'b00;
      cfg_msb_first = 1'b0;
      cfg_stop_halves = 3'd0; push(9'h015); wait_pop(); check_frame(9'h015, 1'b1);
      cfg_stop_halves = 3'd7; push(9'h00A); wait_pop(); check_frame(9'h00A, 1'b1);
      // R3 clamping: 3 acts as 5, 12 acts as 9
      cfg_oversample = 8'd4; cfg_stop_halves = 3'd2;
      cfg_data_bits = 4'd3;  push(9'h1F3); wait_pop(); check_frame(9'h1F3, 1'b1);
      cfg_data_bits = 4'd12; push(9'h1A6); wait_pop(); check_frame(9'h1A6, 1'b1);

      // R7: back-to-back frames, no idle gap
      cfg_data_bits = 4'd8; cfg_parity = 2'b01; cfg_stop_halves = 3'd3;
      push(9'h0C3); push(9'h03C);
      wait_pop();
      check_frame(9'h0C3, 1'b0);
      check_frame(9'h03C, 1'b1);

      // R8: active-high CTS blocks, then allows
      cfg_parity = 2'b00; cfg_stop_halves = 3'd2;
      cfg_cts_en = 1'b1; cfg_cts_low = 1'b0; cts_in = 1'b0;
      push(9'h055);
      expect_quiet(20, "R8");
      cts_in = 1'b1;
      wait_pop();
      // R9: drop CTS right after start, frame must complete
      drop_cts = 1'b1;
      check_frame(9'h055, 1'b1);
      drop_cts = 1'b0;
      push(9'h0AA);
      expect_quiet(20, "R9");
      // R8: active-low polarity; 1 is inactive, 0 is active
      cfg_cts_low = 1'b1; cts_in = 1'b1;
      expect_quiet(12, "R8");
      cts_in = 1'b0;
      wait_pop();
      check_frame(9'h0AA, 1'b1);
      cfg_cts_en = 1'b0;

      // R10: multiprocessor marker frames, parity and width ignored
      cfg_mp_en = 1'b1; cfg_parity = 2'b01; cfg_data_bits = 4'd5;
      cfg_msb_first = 1'b0; push(9'h1A5); wait_pop(); check_frame(9'h1A5, 1'b1);
      cfg_msb_first = 1'b1; push(9'h05A); wait_pop(); check_frame(9'h05A, 1'b1);
      cfg_parity = 2'b10;   push(9'h181); wait_pop(); check_frame(9'h181, 1'b1);
      cfg_mp_en = 1'b0;

      expect_quiet(5, "R1");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule